// File: doc/BRIEF.md
# Zigzag Scan Address Generator

This block produces the visiting order for an 8x8 block of samples in the zigzag order used by block-transform image coders. After a start pulse it puts out one coordinate pair per accepted cycle: column `x` and row `y`, both counted from 1. It also puts out the matching linear address into a row-major buffer. A `last` flag marks the final coordinate. The consumer takes each coordinate through a valid/ready handshake.

The order comes from a counter-style sequencer, not from a stored table. Four step primitives exist: one step east, one step south, a run down-left and a run up-right. Each diagonal run stops when it meets a block edge, or after at most 8 steps. A fixed program of these primitives walks the upper-left triangle of the block. It then runs the main anti-diagonal. Last, it replays the first-half program in reverse order with the edge tests mirrored, which walks the lower-right triangle and ends at the far corner. The block is parameterised by its edge length `N` (even, at least 4). All coordinate, address and counter widths derive from `N`.

Top module: `zz_scan_gen`

## Requirements
- R1: With `valid_o` low, a `start_i` pulse makes the next cycle show `valid_o`=1, `x_o`=1, `y_o`=1, `addr_o`=0 and `last_o`=0.
- R2: The coordinates accepted after one start follow the zigzag order, with each of the 64 positions visited once. On diagonal d = (x-1)+(y-1), the row falls for even d and rises for odd d. The sequence is (1,1),(2,1),(1,2),(1,3),(2,2),(3,1),... and ends with (7,8),(8,8).
- R3: Each coordinate after an accepted non-final one differs from it by exactly one of (+1,0), (0,+1), (-1,+1) or (+1,-1).
- R4: `last_o` is high only with the 64th coordinate, which is (8,8). After that coordinate is accepted, `valid_o` is low in the next cycle.
- R5: While `valid_o` is high, `addr_o` equals (y-1)*8 + (x-1), held in the same cycle as the coordinate.
- R6: While `valid_o` is high and `ready_i` is low, `x_o`, `y_o`, `addr_o`, `last_o` and `valid_o` keep their values into the next cycle, and the walk resumes where it stopped.
- R7: A `start_i` pulse while `valid_o` is high has no effect on the coordinate sequence.
- R8: After reset `valid_o` and `last_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new walk when idle |
| ready_i | input | 1 | Consumer accepts the shown coordinate this cycle |
| valid_o | output | 1 | A coordinate is being offered |
| x_o | output | 4 | Column, 1..8 |
| y_o | output | 4 | Row, 1..8 |
| addr_o | output | 6 | Row-major linear address |
| last_o | output | 1 | Offered coordinate is the final one |

## Verification
The bench builds the zigzag order from the diagonal rule and follows the handshake every cycle. The riskiest points are the run stops at the two corners (8,1) and (1,8), and the hand-over from the main diagonal into the mirrored half. A sequencer that got the mirrored edge tests wrong would run past the block edge or stop one position early, and the order would split at entry 29 or later. Random ready stalls, a stall held on the final coordinate, and start held high through a whole walk probe a design that lets state advance during a stall or lets a restart cut into a running walk. A restart in the cycle right after completion checks that the block returns cleanly to its first coordinate.

// File: rtl/zz_pkg.sv
package zz_pkg;

    // Primitive scan moves
    typedef enum logic [1:0] {
        MV_EAST  = 2'd0,
        MV_SOUTH = 2'd1,
        MV_SW    = 2'd2,
        MV_NE    = 2'd3
    } move_e;

    // Program phases of the walk
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_LEAD   = 3'd1,
        PH_BODY   = 3'd2,
        PH_DIAG   = 3'd3,
        PH_MIRROR = 3'd4,
        PH_TAIL   = 3'd5,
        PH_DONE   = 3'd6
    } phase_e;

endpackage

// File: rtl/zz_step_unit.sv
// Applies one primitive step to a coordinate and reports whether a run
// primitive has reached its stopping edge after this step.
module zz_step_unit
    import zz_pkg::*;
#(
    parameter int N  = 8,
    parameter int CW = 4
) (
    input  move_e         move_i,
    input  logic          mirror_i,
    input  logic [CW-1:0] x_i,
    input  logic [CW-1:0] y_i,
    output logic [CW-1:0] x_o,
    output logic [CW-1:0] y_o,
    output logic          edge_o
);
    localparam logic [CW-1:0] ONE  = CW'(1);
    localparam logic [CW-1:0] EDGE = CW'(N);

    logic [CW-1:0] nx;
    logic [CW-1:0] ny;

    always_comb begin
        nx     = x_i;
        ny     = y_i;
        edge_o = 1'b1;
        case (move_i)
            MV_EAST: begin
                nx = x_i + ONE;
            end
            MV_SOUTH: begin
                ny = y_i + ONE;
            end
            MV_SW: begin
                nx     = x_i - ONE;
                ny     = y_i + ONE;
                // first half stops on left column, mirrored half on bottom row
                edge_o = mirror_i ? (ny == EDGE) : (nx == ONE);
            end
            default: begin
                nx     = x_i + ONE;
                ny     = y_i - ONE;
                // first half stops on top row, mirrored half on right column
                edge_o = mirror_i ? (nx == EDGE) : (ny == ONE);
            end
        endcase
    end

    assign x_o = nx;
    assign y_o = ny;

endmodule

// File: rtl/zz_sequencer.sv
// Program of the walk: selects the current primitive from phase and slot,
// and gives the program position that follows once that primitive ends.
module zz_sequencer
    import zz_pkg::*;
#(
    parameter int LOOPS = 3,
    parameter int LW    = 2
) (
    input  phase_e        phase_i,
    input  logic [1:0]    slot_i,
    input  logic [LW-1:0] loop_i,
    output move_e         move_o,
    output logic          mirror_o,
    output phase_e        phase_o,
    output logic [1:0]    slot_o,
    output logic [LW-1:0] loop_o
);
    localparam logic [LW-1:0] LOOP_LAST = LW'(LOOPS - 1);

    // Body of the first half, in slot order
    function automatic move_e body_move(input logic [1:0] s);
        case (s)
            2'd0:    return MV_SW;
            2'd1:    return MV_SOUTH;
            2'd2:    return MV_NE;
            default: return MV_EAST;
        endcase
    endfunction

    // Mirrored body: first-half moves taken in reverse slot order.
    // Reflection and reversal each negate a step, so vectors are kept.
    function automatic move_e mirror_move(input logic [1:0] s);
        return body_move(2'd3 - s);
    endfunction

    logic last_slot;
    logic last_loop;

    always_comb begin
        last_slot = (slot_i == 2'd3);
        last_loop = (loop_i == LOOP_LAST);

        case (phase_i)
            PH_BODY:   move_o = body_move(slot_i);
            PH_DIAG:   move_o = MV_SW;
            PH_MIRROR: move_o = mirror_move(slot_i);
            default:   move_o = MV_EAST;
        endcase
        mirror_o = (phase_i == PH_MIRROR) || (phase_i == PH_TAIL);

        phase_o = phase_i;
        slot_o  = slot_i;
        loop_o  = loop_i;
        case (phase_i)
            PH_LEAD: begin
                phase_o = PH_BODY;
                slot_o  = 2'd0;
                loop_o  = '0;
            end
            PH_BODY, PH_MIRROR: begin
                if (!last_slot) begin
                    slot_o = slot_i + 2'd1;
                end else if (!last_loop) begin
                    slot_o = 2'd0;
                    loop_o = loop_i + LW'(1);
                end else begin
                    phase_o = (phase_i == PH_BODY) ? PH_DIAG : PH_TAIL;
                    slot_o  = 2'd0;
                    loop_o  = '0;
                end
            end
            PH_DIAG: begin
                phase_o = PH_MIRROR;
                slot_o  = 2'd0;
                loop_o  = '0;
            end
            PH_TAIL: begin
                phase_o = PH_DONE;
            end
            default: begin
                phase_o = phase_i;
            end
        endcase
    end

endmodule

// File: rtl/zz_addr_map.sv
// Row-major linear address from 1-based coordinates.
module zz_addr_map #(
    parameter int N  = 8,
    parameter int CW = 4,
    parameter int AW = 6
) (
    input  logic [CW-1:0] x_i,
    input  logic [CW-1:0] y_i,
    output logic [AW-1:0] addr_o
);
    localparam int  PW      = $clog2(N);
    localparam bit  IS_POW2 = ((1 << PW) == N);

    logic [CW-1:0] xm1;
    logic [CW-1:0] ym1;

    assign xm1 = x_i - CW'(1);
    assign ym1 = y_i - CW'(1);

    generate
        if (IS_POW2) begin : g_shift
            assign addr_o = (AW'(ym1) << PW) | AW'(xm1);
        end else begin : g_mult
            assign addr_o = AW'(ym1) * AW'(N) + AW'(xm1);
        end
    endgenerate

endmodule

// File: rtl/zz_scan_gen.sv
// Zigzag scan address generator: sequencer of primitive step moves.
module zz_scan_gen
    import zz_pkg::*;
#(
    parameter int N = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic                      ready_i,
    output logic                      valid_o,
    output logic [$clog2(N+1)-1:0]    x_o,
    output logic [$clog2(N+1)-1:0]    y_o,
    output logic [$clog2(N*N)-1:0]    addr_o,
    output logic                      last_o
);
    localparam int CW    = $clog2(N + 1);
    localparam int AW    = $clog2(N * N);
    localparam int LOOPS = (N - 2) / 2;
    localparam int LW    = (LOOPS > 1) ? $clog2(LOOPS) : 1;
    localparam int RW    = $clog2(N + 1);
    localparam logic [RW-1:0] RUN_MAX = RW'(N - 1);

    typedef struct packed {
        phase_e        phase;
        logic [1:0]    slot;
        logic [LW-1:0] loop;
        logic [RW-1:0] run;
        logic [CW-1:0] x;
        logic [CW-1:0] y;
        logic          valid;
        logic          last;
    } state_t;

    state_t        s_q;
    state_t        s_d;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] addr_d;

    move_e         cur_move;
    logic          cur_mirror;
    phase_e        nxt_phase;
    logic [1:0]    nxt_slot;
    logic [LW-1:0] nxt_loop;
    logic [CW-1:0] step_x;
    logic [CW-1:0] step_y;
    logic          step_edge;
    logic          run_done;

    zz_sequencer #(
        .LOOPS(LOOPS),
        .LW   (LW)
    ) seq_i (
        .phase_i (s_q.phase),
        .slot_i  (s_q.slot),
        .loop_i  (s_q.loop),
        .move_o  (cur_move),
        .mirror_o(cur_mirror),
        .phase_o (nxt_phase),
        .slot_o  (nxt_slot),
        .loop_o  (nxt_loop)
    );

    zz_step_unit #(
        .N (N),
        .CW(CW)
    ) step_i (
        .move_i  (cur_move),
        .mirror_i(cur_mirror),
        .x_i     (s_q.x),
        .y_i     (s_q.y),
        .x_o     (step_x),
        .y_o     (step_y),
        .edge_o  (step_edge)
    );

    // single steps report an edge at once; runs end at an edge or after N steps
    assign run_done = step_edge || (s_q.run == RUN_MAX);

    always_comb begin
        s_d = s_q;
        if (!s_q.valid) begin
            if (start_i) begin
                s_d.phase = PH_LEAD;
                s_d.slot  = 2'd0;
                s_d.loop  = '0;
                s_d.run   = '0;
                s_d.x     = CW'(1);
                s_d.y     = CW'(1);
                s_d.valid = 1'b1;
                s_d.last  = 1'b0;
            end
        end else if (ready_i) begin
            if (s_q.last) begin
                s_d.phase = PH_IDLE;
                s_d.valid = 1'b0;
                s_d.last  = 1'b0;
                s_d.run   = '0;
            end else begin
                s_d.x = step_x;
                s_d.y = step_y;
                if (run_done) begin
                    s_d.phase = nxt_phase;
                    s_d.slot  = nxt_slot;
                    s_d.loop  = nxt_loop;
                    s_d.run   = '0;
                    s_d.last  = (nxt_phase == PH_DONE);
                end else begin
                    s_d.run = s_q.run + RW'(1);
                end
            end
        end
    end

    zz_addr_map #(
        .N (N),
        .CW(CW),
        .AW(AW)
    ) map_i (
        .x_i   (s_d.x),
        .y_i   (s_d.y),
        .addr_o(addr_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase <= PH_IDLE;
            s_q.slot  <= '0;
            s_q.loop  <= '0;
            s_q.run   <= '0;
            s_q.x     <= '0;
            s_q.y     <= '0;
            s_q.valid <= 1'b0;
            s_q.last  <= 1'b0;
            addr_q    <= '0;
        end else begin
            s_q    <= s_d;
            addr_q <= addr_d;
        end
    end

    assign valid_o = s_q.valid;
    assign x_o     = s_q.x;
    assign y_o     = s_q.y;
    assign addr_o  = addr_q;
    assign last_o  = s_q.last;

endmodule

// File: rtl/zz_scan_chk.sv
// Property checker for the zigzag scan generator.
module zz_scan_chk #(
    parameter int N = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start_i,
    input logic                   ready_i,
    input logic                   valid_o,
    input logic [$clog2(N+1)-1:0] x_o,
    input logic [$clog2(N+1)-1:0] y_o,
    input logic [$clog2(N*N)-1:0] addr_o,
    input logic                   last_o
);
    localparam int CW = $clog2(N + 1);
    localparam int AW = $clog2(N * N);

    logic          hs_q;
    logic [CW-1:0] px_q;
    logic [CW-1:0] py_q;
    logic [AW-1:0] cnt_q;
    logic          legal;
    int            dx;
    int            dy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q  <= 1'b0;
            px_q  <= '0;
            py_q  <= '0;
            cnt_q <= '0;
        end else begin
            hs_q <= valid_o && ready_i && !last_o;
            px_q <= x_o;
            py_q <= y_o;
            if (valid_o && ready_i) begin
                cnt_q <= last_o ? '0 : cnt_q + AW'(1);
            end
        end
    end

    always_comb begin
        dx    = int'(x_o) - int'(px_q);
        dy    = int'(y_o) - int'(py_q);
        legal = (dx == 1 && dy == 0) || (dx == 0 && dy == 1) ||
                (dx == -1 && dy == 1) || (dx == 1 && dy == -1);
    end

    // R1
    start_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && start_i) |=> (valid_o && x_o == CW'(1) && y_o == CW'(1)
                                   && addr_o == '0 && !last_o));

    // R2
    in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (x_o >= CW'(1) && x_o <= CW'(N) && y_o >= CW'(1) && y_o <= CW'(N)));

    // R3
    legal_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_q |-> (valid_o && legal));

    // R4
    last_corner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> (valid_o && x_o == CW'(N) && y_o == CW'(N)));

    // R4
    last_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (last_o == (cnt_q == AW'(N * N - 1))));

    // R4
    end_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready_i && last_o) |=> !valid_o);

    // R5
    addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (int'(addr_o) == (int'(y_o) - 1) * N + (int'(x_o) - 1)));

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(x_o) && $stable(y_o)
                                   && $stable(addr_o) && $stable(last_o)));

    // R7
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready_i && !last_o && start_i) |=> !(x_o == CW'(1) && y_o == CW'(1)));

    // R8
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |-> (!valid_o && !last_o));

endmodule

bind zz_scan_gen zz_scan_chk #(.N(N)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .ready_i(ready_i),
    .valid_o(valid_o),
    .x_o    (x_o),
    .y_o    (y_o),
    .addr_o (addr_o),
    .last_o (last_o)
);

// File: tb/zz_scan_gen_tb_top.sv
`timescale 1ns / 1ps
module zz_scan_gen_tb_top;
    localparam int N  = 8;
    localparam int CW = 4;
    localparam int AW = 6;
    localparam int LASTIDX = N * N - 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start_i;
    logic          ready_i;
    logic          valid_o;
    logic [CW-1:0] x_o;
    logic [CW-1:0] y_o;
    logic [AW-1:0] addr_o;
    logic          last_o;

    always #5 clk = ~clk;

    zz_scan_gen #(.N(N)) dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_i),
        .ready_i(ready_i),
        .valid_o(valid_o),
        .x_o    (x_o),
        .y_o    (y_o),
        .addr_o (addr_o),
        .last_o (last_o)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int ex[N*N];
    int ey[N*N];

    // reference model state
    bit m_busy = 0;
    int m_idx  = 0;

    // previous-cycle observations
    bit            p_hold = 0;
    logic [CW-1:0] p_x;
    logic [CW-1:0] p_y;
    logic [AW-1:0] p_a;
    logic          p_l;
    bit            p_hs = 0;
    int            h_x;
    int            h_y;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic build_order();
        int k = 0;
        for (int d = 0; d <= 2 * N - 2; d++) begin
            for (int i = 0; i <= d; i++) begin
                int r = (d % 2 == 0) ? d - i : i;
                int c = d - r;
                if (r < N && c < N) begin
                    ex[k] = c + 1;
                    ey[k] = r + 1;
                    k++;
                end
            end
        end
    endtask

    // one clock: check outputs, drive inputs, advance model
    task automatic tick(input logic s, input logic r, input string busy_tag);
        string rq;
        int dx;
        int dy;
        @(negedge clk);
        if (!m_busy) begin
            chk(valid_o == 1'b0, "R4", "valid while idle", int'(valid_o), 0);
        end else begin
            rq = (m_idx == 0) ? "R1" : ((busy_tag != "") ? busy_tag : "R2");
            chk(valid_o == 1'b1, rq, "valid", int'(valid_o), 1);
            chk(int'(x_o) == ex[m_idx], rq, "x", int'(x_o), ex[m_idx]);
            chk(int'(y_o) == ey[m_idx], rq, "y", int'(y_o), ey[m_idx]);
            chk(last_o == (m_idx == LASTIDX), "R4", "last", int'(last_o),
                int'(m_idx == LASTIDX));
            chk(int'(addr_o) == (ey[m_idx] - 1) * N + ex[m_idx] - 1, "R5", "addr",
                int'(addr_o), (ey[m_idx] - 1) * N + ex[m_idx] - 1);
        end
        if (p_hold) begin
            chk(valid_o && x_o == p_x && y_o == p_y && addr_o == p_a && last_o == p_l,
                "R6", "held addr", int'(addr_o), int'(p_a));
        end
        if (p_hs) begin
            dx = int'(x_o) - h_x;
            dy = int'(y_o) - h_y;
            chk((dx == 1 && dy == 0) || (dx == 0 && dy == 1) ||
                (dx == -1 && dy == 1) || (dx == 1 && dy == -1),
                "R3", "step dx*16+dy", dx * 16 + dy, 0);
        end
        start_i = s;
        ready_i = r;
        p_hold = m_busy && !r;
        p_x = x_o;
        p_y = y_o;
        p_a = addr_o;
        p_l = last_o;
        p_hs = m_busy && r && (m_idx != LASTIDX);
        h_x = int'(x_o);
        h_y = int'(y_o);
        if (!m_busy) begin
            if (s) begin
                m_busy = 1;
                m_idx = 0;
            end
        end else if (r) begin
            if (m_idx == LASTIDX) m_busy = 0;
            else m_idx++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        int guard;
        build_order();
        rst_n   = 1'b0;
        start_i = 1'b0;
        ready_i = 1'b0;
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(valid_o == 1'b0, "R8", "valid in reset", int'(valid_o), 0);
        chk(last_o == 1'b0, "R8", "last in reset", int'(last_o), 0);
        rst_n = 1'b1;
        tick(0, 0, "");
        chk(valid_o == 1'b0, "R8", "valid after reset", int'(valid_o), 0);

        // full-rate walk (R1, R2, R3, R4, R5)
        tick(1, 1, "");
        repeat (70) tick(0, 1, "");

        // random ready stalls (R6)
        tick(1, 0, "");
        guard = 0;
        while (m_busy && guard < 2000) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            tick(0, lfsr[0] | lfsr[5], "");
            guard++;
        end
        repeat (3) tick(0, 1, "");

        // start held high through a walk (R7), restart right after the end
        tick(1, 1, "");
        guard = 0;
        while (m_busy && guard < 2000) begin
            tick(1, (guard % 3) != 0, "R7");
            guard++;
        end
        guard = 0;
        while (m_busy && guard < 2000) begin
            tick(0, 1, "");
            guard++;
        end

        // stall held on the final coordinate (R4, R6)
        tick(1, 1, "");
        guard = 0;
        while (m_idx != LASTIDX && guard < 2000) begin
            tick(0, 1, "");
            guard++;
        end
        repeat (5) tick(0, 0, "");
        tick(0, 1, "");
        repeat (3) tick(0, 0, "");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule